// File: doc/BRIEF.md
# Queued-Opcode Quad SPI Sequencer

This block is a half-duplex SPI master that runs entirely from a queue of small operation words. Each word carries a five-bit command code and a nine-bit byte count. The command can move chip select, shift bytes out on one, two or four data lanes, or shift bytes in on one, two or four lanes. A set of turnaround commands shifts bytes out and then hands selected lanes back to the attached device for input. Bytes travel through one byte-wide data FIFO: software fills it before or during an output command and drains it during or after an input command.

Software stages a word on `op_word` and pulses `op_push`. The engine fetches queued words in order and runs each to completion. The serial clock runs at half the system clock and idles low (SPI mode 0). If the data FIFO has no byte to send, or no room for a received byte, the engine stops the serial clock between bytes and resumes without losing a bit. `op_empty` rises only after the last queued command has finished.

Top module: `qsq_top`

## Requirements
- R1: An operation word is {code[4:0], count[8:0]}, with the code in bits 13:9. `op_full` is high while OP_DEPTH (default 4) words wait in the queue, and a push while it is high is dropped.
- R2: `op_empty` is high only when no word is queued and no command is executing.
- R3: Code 0x01 drives `cs_n` low and code 0x00 drives it high and releases every lane (`io_oe` = 0). The count of either is ignored. `cs_n` resets high.
- R4: Codes 0x08, 0x09 and 0x0A send `count` bytes from the data FIFO on 1, 2 or 4 lanes, most significant bits first. Single uses `io_out[0]`, dual uses `io_out[1:0]` (bits 7:6 first) and quad uses `io_out[3:0]` (high nibble first). Each byte takes 8, 4 or 2 serial clocks.
- R5: Codes 0x0C, 0x0E and 0x0F receive `count` bytes on 1, 2 or 4 lanes, MSB first, and push them into the data FIFO. Single samples `io_in[1]`, dual samples `io_in[1:0]` and quad samples `io_in[3:0]`.
- R6: Codes 0x10 to 0x18 equal 0x10 + 3*o + i, where o is the output width and i is the input width (0 single, 1 dual, 2 quad). They send like R4 at width o. When they finish, `io_oe` equals the output lane mask with the input lane mask cleared. Output masks are 0001, 0011, 1111; input masks are 0010, 0011, 1111.
- R7: A plain output command sets `io_oe` to its output mask, and that mask stays set after the command ends. An input command clears its input lanes in `io_oe` before any bit is sampled, so no receiving lane is ever driven.
- R8: While an output command has no byte to send, `sck` stays low and the command does not finish. The next byte resumes the transfer with no bit lost.
- R9: While an input command finds the data FIFO full at a byte start, `sck` stays low. The engine never pushes into a full FIFO, and no received byte is lost.
- R10: `sck` is the system clock divided by 2 and idles low. Each high phase lasts one system clock, and `io_out` changes only while `sck` is low.
- R11: Codes outside those listed above (for example 0x05, 0x0D, 0x1F) are taken from the queue and do nothing. `cs_n`, `io_oe`, `sck` and the data FIFO are left unchanged.
- R12: The data FIFO holds DAT_DEPTH bytes (default 8). `dat_full` and `dat_empty` report its state. `dat_rdata` shows the oldest byte, and `dat_pop` removes it. A push while full and a pop while empty are ignored.
- R13: After reset, `sck` is 0, `cs_n` is 1, `io_oe` is 0, both FIFOs are empty, and `op_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_word | input | 14 | Staged operation word {code, count} |
| op_push | input | 1 | Pushes `op_word` into the operation queue |
| op_full | output | 1 | Operation queue full |
| op_empty | output | 1 | Queue empty and engine idle |
| dat_wdata | input | 8 | Byte to enqueue for sending |
| dat_push | input | 1 | Pushes `dat_wdata` into the data FIFO |
| dat_full | output | 1 | Data FIFO full |
| dat_rdata | output | 8 | Oldest byte in the data FIFO |
| dat_pop | input | 1 | Removes the oldest data byte |
| dat_empty | output | 1 | Data FIFO empty |
| sck | output | 1 | Serial clock, mode 0 |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Data lane output values |
| io_oe | output | 4 | Data lane output enables |
| io_in | input | 4 | Data lane input values |

## Verification
Some properties are checked on every cycle. These are: the one-cycle high phase of `sck`; `io_out` holding steady across each rising edge; `sck` staying low whenever the engine reports idle; no receiving lane being driven during an input command; and the engine never pushing into a full data FIFO or popping an empty one. Other behaviour can only be shown by the bench's scenarios. This covers bit order and lane placement at each width, the turnaround lane masks for all nine codes, and the dropped queue push. It also covers no-op handling of undefined codes, and the proof that a stalled transfer loses no bit once data or space returns.

// File: rtl/qsq_pkg.sv
package qsq_pkg;

    localparam int CODE_W = 5;
    localparam int CNT_W  = 9;
    localparam int WORD_W = CODE_W + CNT_W;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;

    typedef enum logic [2:0] {
        K_NOP,
        K_CS_HI,
        K_CS_LO,
        K_SEND,
        K_RECV,
        K_TURN
    } kind_e;

    typedef enum logic [1:0] {
        MD_SEND,
        MD_RECV,
        MD_TURN
    } mode_e;

    typedef struct packed {
        kind_e      kind;
        logic [1:0] ow;
        logic [1:0] iw;
    } dec_t;

    typedef struct packed {
        logic              busy;
        mode_e             mode;
        logic [1:0]        ow;
        logic [1:0]        iw;
        logic [CNT_W-1:0]  left;
        logic [3:0]        steps;
        logic [BYTE_W-1:0] sh;
        logic              sck;
        logic              cs_n;
        logic [LANES-1:0]  oe;
    } eng_t;

    // Width code: 0 single, 1 dual, 2 quad
    function automatic dec_t decode_code(input logic [CODE_W-1:0] c);
        dec_t       r;
        logic [4:0] t;
        r.kind = K_NOP;
        r.ow   = 2'd0;
        r.iw   = 2'd0;
        t      = c - 5'h10;
        if (c == 5'h00) begin
            r.kind = K_CS_HI;
        end else if (c == 5'h01) begin
            r.kind = K_CS_LO;
        end else if (c >= 5'h08 && c <= 5'h0A) begin
            r.kind = K_SEND;
            r.ow   = c[1:0];
        end else if (c == 5'h0C) begin
            r.kind = K_RECV;
            r.iw   = 2'd0;
        end else if (c == 5'h0E) begin
            r.kind = K_RECV;
            r.iw   = 2'd1;
        end else if (c == 5'h0F) begin
            r.kind = K_RECV;
            r.iw   = 2'd2;
        end else if (c >= 5'h10 && c <= 5'h18) begin
            r.kind = K_TURN;
            r.ow   = 2'(t / 5'd3);
            r.iw   = 2'(t % 5'd3);
        end
        return r;
    endfunction

    function automatic logic [LANES-1:0] send_lanes(input logic [1:0] w);
        case (w)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [LANES-1:0] recv_lanes(input logic [1:0] w);
        case (w)
            2'd0:    return 4'b0010;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [3:0] steps_per_byte(input logic [1:0] w);
        case (w)
            2'd0:    return 4'd8;
            2'd1:    return 4'd4;
            default: return 4'd2;
        endcase
    endfunction

endpackage

// File: rtl/qsq_fifo.sv
module qsq_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW:0]   FULL_CNT = (AW + 1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [AW:0]   cnt;
    } ptr_t;

    ptr_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (q.cnt == FULL_CNT);
    assign empty   = (q.cnt == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign rdata   = mem[q.rd];

    always_comb begin
        d = q;
        if (do_push) begin
            d.wr = (q.wr == LAST) ? '0 : q.wr + 1'b1;
        end
        if (do_pop) begin
            d.rd = (q.rd == LAST) ? '0 : q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[q.wr] <= wdata;
        end
    end

endmodule

// File: rtl/qsq_engine.sv
module qsq_engine
    import qsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [WORD_W-1:0] op_head,
    output logic              op_take,
    input  logic              dat_is_empty,
    input  logic              dat_is_full,
    input  logic [BYTE_W-1:0] dat_head,
    output logic              eng_pop,
    output logic              eng_push,
    output logic [BYTE_W-1:0] eng_byte,
    output logic              sck,
    output logic              cs_n,
    output logic [LANES-1:0]  io_out,
    output logic [LANES-1:0]  io_oe,
    input  logic [LANES-1:0]  io_in,
    output logic              busy,
    output logic              rx_phase,
    output logic [LANES-1:0]  rx_lanes
);
    eng_t q, d;
    dec_t dec;

    localparam eng_t RESET_STATE = '{
        busy:  1'b0,
        mode:  MD_SEND,
        ow:    2'd0,
        iw:    2'd0,
        left:  '0,
        steps: 4'd0,
        sh:    '0,
        sck:   1'b0,
        cs_n:  1'b1,
        oe:    '0
    };

    assign dec = decode_code(op_head[WORD_W-1:CNT_W]);

    always_comb begin
        d        = q;
        op_take  = 1'b0;
        eng_pop  = 1'b0;
        eng_push = 1'b0;
        eng_byte = q.sh;
        if (!q.busy) begin
            // Fetch: chip-select and undefined codes complete here
            if (op_valid) begin
                op_take = 1'b1;
                case (dec.kind)
                    K_CS_HI: begin
                        d.cs_n = 1'b1;
                        d.oe   = '0;
                    end
                    K_CS_LO: begin
                        d.cs_n = 1'b0;
                    end
                    K_SEND, K_TURN: begin
                        d.busy  = 1'b1;
                        d.mode  = (dec.kind == K_SEND) ? MD_SEND : MD_TURN;
                        d.ow    = dec.ow;
                        d.iw    = dec.iw;
                        d.left  = op_head[CNT_W-1:0];
                        d.steps = 4'd0;
                        d.oe    = send_lanes(dec.ow);
                    end
                    K_RECV: begin
                        d.busy  = 1'b1;
                        d.mode  = MD_RECV;
                        d.iw    = dec.iw;
                        d.left  = op_head[CNT_W-1:0];
                        d.steps = 4'd0;
                        d.oe    = q.oe & ~recv_lanes(dec.iw);
                    end
                    default: ;
                endcase
            end
        end else if (q.steps == 4'd0) begin
            // Byte boundary: finish, or start the next byte if possible
            if (q.left == '0) begin
                d.busy = 1'b0;
                if (q.mode == MD_TURN) begin
                    d.oe = send_lanes(q.ow) & ~recv_lanes(q.iw);
                end
            end else if (q.mode == MD_RECV) begin
                if (!dat_is_full) begin
                    d.steps = steps_per_byte(q.iw);
                    d.left  = q.left - 1'b1;
                end
            end else if (!dat_is_empty) begin
                eng_pop = 1'b1;
                d.sh    = dat_head;
                d.steps = steps_per_byte(q.ow);
                d.left  = q.left - 1'b1;
            end
        end else if (!q.sck) begin
            // Rising edge: sample receive lanes
            d.sck = 1'b1;
            if (q.mode == MD_RECV) begin
                case (q.iw)
                    2'd0:    d.sh = {q.sh[6:0], io_in[1]};
                    2'd1:    d.sh = {q.sh[5:0], io_in[1:0]};
                    default: d.sh = {q.sh[3:0], io_in[3:0]};
                endcase
            end
        end else begin
            // Falling edge: advance to the next bit group
            d.sck   = 1'b0;
            d.steps = q.steps - 1'b1;
            if (q.mode == MD_RECV) begin
                if (q.steps == 4'd1) begin
                    eng_push = 1'b1;
                end
            end else begin
                case (q.ow)
                    2'd0:    d.sh = {q.sh[6:0], 1'b0};
                    2'd1:    d.sh = {q.sh[5:0], 2'b00};
                    default: d.sh = {q.sh[3:0], 4'b0000};
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET_STATE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        if (q.mode == MD_RECV) begin
            io_out = '0;
        end else begin
            case (q.ow)
                2'd0:    io_out = {3'b000, q.sh[7]};
                2'd1:    io_out = {2'b00, q.sh[7:6]};
                default: io_out = q.sh[7:4];
            endcase
        end
    end

    assign sck      = q.sck;
    assign cs_n     = q.cs_n;
    assign io_oe    = q.oe;
    assign busy     = q.busy;
    assign rx_phase = q.busy && (q.mode == MD_RECV);
    assign rx_lanes = recv_lanes(q.iw);

endmodule

// File: rtl/qsq_top.sv
module qsq_top
    import qsq_pkg::*;
#(
    parameter int OP_DEPTH  = 4,
    parameter int DAT_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [13:0] op_word,
    input  logic        op_push,
    output logic        op_full,
    output logic        op_empty,
    input  logic [7:0]  dat_wdata,
    input  logic        dat_push,
    output logic        dat_full,
    output logic [7:0]  dat_rdata,
    input  logic        dat_pop,
    output logic        dat_empty,
    output logic        sck,
    output logic        cs_n,
    output logic [3:0]  io_out,
    output logic [3:0]  io_oe,
    input  logic [3:0]  io_in
);
    logic              opq_empty;
    logic [WORD_W-1:0] opq_head;
    logic              op_take;
    logic              eng_pop;
    logic              eng_push;
    logic [BYTE_W-1:0] eng_byte;
    logic              busy;
    logic              rx_phase;
    logic [LANES-1:0]  in_mask;
    logic              dq_push;
    logic              dq_pop;
    logic [BYTE_W-1:0] dq_wdata;

    qsq_fifo #(
        .WIDTH (WORD_W),
        .DEPTH (OP_DEPTH)
    ) u_opq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (op_push),
        .wdata (op_word),
        .pop   (op_take),
        .rdata (opq_head),
        .full  (op_full),
        .empty (opq_empty)
    );

    // Engine and software share the data FIFO; half-duplex use keeps them apart
    assign dq_push  = dat_push | eng_push;
    assign dq_pop   = dat_pop | eng_pop;
    assign dq_wdata = eng_push ? eng_byte : dat_wdata;

    qsq_fifo #(
        .WIDTH (BYTE_W),
        .DEPTH (DAT_DEPTH)
    ) u_datq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (dq_push),
        .wdata (dq_wdata),
        .pop   (dq_pop),
        .rdata (dat_rdata),
        .full  (dat_full),
        .empty (dat_empty)
    );

    qsq_engine u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid     (~opq_empty),
        .op_head      (opq_head),
        .op_take      (op_take),
        .dat_is_empty (dat_empty),
        .dat_is_full  (dat_full),
        .dat_head     (dat_rdata),
        .eng_pop      (eng_pop),
        .eng_push     (eng_push),
        .eng_byte     (eng_byte),
        .sck          (sck),
        .cs_n         (cs_n),
        .io_out       (io_out),
        .io_oe        (io_oe),
        .io_in        (io_in),
        .busy         (busy),
        .rx_phase     (rx_phase),
        .rx_lanes     (in_mask)
    );

    assign op_empty = opq_empty & ~busy;

endmodule

// File: rtl/qsq_checker.sv
module qsq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sck,
    input logic [3:0] io_out,
    input logic [3:0] io_oe,
    input logic       op_empty,
    input logic       rx_phase,
    input logic [3:0] in_mask,
    input logic       eng_push,
    input logic       eng_pop,
    input logic       dat_full,
    input logic       dat_empty
);
    assert_one_high_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |=> $fell(sck));

    assert_data_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(io_out));

    assert_idle_sck_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_empty |-> !sck);

    assert_half_duplex_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_phase |-> ((io_oe & in_mask) == 4'b0000));

    assert_no_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_push |-> !dat_full);

    assert_no_underrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_pop |-> !dat_empty);

endmodule

bind qsq_top qsq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck       (sck),
    .io_out    (io_out),
    .io_oe     (io_oe),
    .op_empty  (op_empty),
    .rx_phase  (rx_phase),
    .in_mask   (in_mask),
    .eng_push  (eng_push),
    .eng_pop   (eng_pop),
    .dat_full  (dat_full),
    .dat_empty (dat_empty)
);

// File: tb/qsq_top_tb.sv
`timescale 1ns/1ps
module qsq_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] op_word = '0;
    logic        op_push = 1'b0;
    logic        op_full, op_empty;
    logic [7:0]  dat_wdata = '0;
    logic        dat_push = 1'b0;
    logic        dat_full;
    logic [7:0]  dat_rdata;
    logic        dat_pop = 1'b0;
    logic        dat_empty;
    logic        sck, cs_n;
    logic [3:0]  io_out, io_oe;
    logic [3:0]  io_in;

    always #2.5 clk = ~clk;

    qsq_top u_dut (
        .clk(clk), .rst_n(rst_n), .op_word(op_word), .op_push(op_push),
        .op_full(op_full), .op_empty(op_empty), .dat_wdata(dat_wdata),
        .dat_push(dat_push), .dat_full(dat_full), .dat_rdata(dat_rdata),
        .dat_pop(dat_pop), .dat_empty(dat_empty), .sck(sck), .cs_n(cs_n),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int omask(input int w);
        return (w == 0) ? 1 : (w == 1) ? 3 : 15;
    endfunction
    function automatic int imask(input int w);
        return (w == 0) ? 2 : (w == 1) ? 3 : 15;
    endfunction
    function automatic int recv_code(input int w);
        return (w == 0) ? 12 : (w == 1) ? 14 : 15;
    endfunction
    function automatic int spb(input int w);
        return 8 >> w;
    endfunction

    // Device model: capture sent groups at rising sck
    int sck_rises = 0;
    bit cap_en = 0;
    int cap_w = 0, cap_sh = 0, cap_cnt = 0, cap_n = 0;
    int cap_q[64];
    always @(posedge sck) begin
        sck_rises++;
        if (cap_en) begin
            cap_sh  = (cap_sh << (1 << cap_w)) | (int'(io_out) & omask(cap_w));
            cap_cnt = cap_cnt + (1 << cap_w);
            if (cap_cnt >= 8) begin
                cap_q[cap_n % 64] = cap_sh & 255;
                cap_n++;
                cap_cnt = 0;
                cap_sh  = 0;
            end
        end
    end

    // Device model: drive receive groups, advance after each falling sck
    bit rx_act = 0;
    int rx_w = 0;
    int gidx = 0;
    int rx_b[32];
    always @(negedge sck) if (rx_act) gidx++;
    always @* begin
        int bi, g, sh, v;
        bi = gidx / spb(rx_w);
        g  = gidx % spb(rx_w);
        sh = 8 - (g + 1) * (1 << rx_w);
        v  = (rx_b[bi % 32] >> sh) & omask(rx_w);
        if (!rx_act)        io_in = 4'b0000;
        else if (rx_w == 0) io_in = {2'b00, v[0], 1'b0};
        else if (rx_w == 1) io_in = {2'b00, v[1:0]};
        else                io_in = v[3:0];
    end

    int tx[16];

    task automatic push_raw(input int code, input int cnt);
        @(negedge clk);
        op_word = 14'((code << 9) | (cnt & 511));
        op_push = 1'b1;
        @(negedge clk);
        op_push = 1'b0;
    endtask
    task automatic push_op(input int code, input int cnt);
        @(negedge clk);
        while (op_full) @(negedge clk);
        op_word = 14'((code << 9) | (cnt & 511));
        op_push = 1'b1;
        @(negedge clk);
        op_push = 1'b0;
    endtask
    task automatic push_dat(input int b);
        @(negedge clk);
        while (dat_full) @(negedge clk);
        dat_wdata = 8'(b);
        dat_push  = 1'b1;
        @(negedge clk);
        dat_push  = 1'b0;
    endtask
    task automatic push_dat_raw(input int b);
        @(negedge clk);
        dat_wdata = 8'(b);
        dat_push  = 1'b1;
        @(negedge clk);
        dat_push  = 1'b0;
    endtask
    task automatic pop_dat(output int b);
        @(negedge clk);
        while (dat_empty) @(negedge clk);
        b = int'(dat_rdata);
        dat_pop = 1'b1;
        @(negedge clk);
        dat_pop = 1'b0;
    endtask
    task automatic wait_idle();
        @(negedge clk);
        while (!op_empty) @(negedge clk);
    endtask
    task automatic start_cap(input int w);
        cap_w = w; cap_sh = 0; cap_cnt = 0; cap_n = 0; cap_en = 1;
    endtask

    task automatic run_send(input int code, input int w, input int n, input string req);
        int r0;
        for (int i = 0; i < n; i++) begin
            tx[i] = $urandom_range(0, 255);
            push_dat(tx[i]);
        end
        start_cap(w);
        r0 = sck_rises;
        push_op(code, n);
        wait_idle();
        check(cap_n == n, req, cap_n, n);
        for (int i = 0; i < n; i++) check(cap_q[i] == tx[i], req, cap_q[i], tx[i]);
        check(sck_rises - r0 == n * spb(w), "R10", sck_rises - r0, n * spb(w));
        cap_en = 0;
    endtask

    task automatic run_recv(input int w, input int n);
        int b;
        for (int i = 0; i < n; i++) rx_b[i] = $urandom_range(0, 255);
        rx_w = w; gidx = 0; rx_act = 1;
        push_op(recv_code(w), n);
        wait_idle();
        check((int'(io_oe) & imask(w)) == 0, "R7", io_oe, 0);
        for (int i = 0; i < n; i++) begin
            pop_dat(b);
            check(b == rx_b[i], "R5", b, rx_b[i]);
        end
        rx_act = 0;
    endtask

    initial begin
        int b, r0;
        void'($urandom(32'h51D3));
        repeat (3) @(negedge clk);
        // R13: reset state
        check(sck == 0, "R13", sck, 0);
        check(cs_n == 1, "R13", cs_n, 1);
        check(io_oe == 0, "R13", io_oe, 0);
        check(op_empty == 1 && op_full == 0, "R13", op_empty, 1);
        check(dat_empty == 1 && dat_full == 0, "R13", dat_empty, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: chip select, count ignored
        push_op(1, 1); wait_idle();
        check(cs_n == 0, "R3", cs_n, 0);
        run_send(10, 2, 1, "R4");
        push_op(0, 511); wait_idle();
        check(cs_n == 1, "R3", cs_n, 1);
        check(io_oe == 0, "R3", io_oe, 0);

        // R4/R5: each width
        push_op(1, 1);
        for (int w = 0; w < 3; w++) begin
            run_send(8 + w, w, 3, "R4");
            check(int'(io_oe) == omask(w), "R7", io_oe, omask(w));
            run_recv(w, 3);
        end

        // R7: dual send then single receive leaves lane 0 driven
        run_send(9, 1, 1, "R4");
        run_recv(0, 1);
        check(io_oe == 4'b0001, "R7", io_oe, 1);

        // R6: every turnaround code
        for (int o = 0; o < 3; o++) begin
            for (int i = 0; i < 3; i++) begin
                run_send(16 + 3 * o + i, o, 2, "R6");
                check(int'(io_oe) == (omask(o) & ~imask(i)), "R6", io_oe, omask(o) & ~imask(i));
            end
        end

        // R8 and R2: send stalls with no data
        start_cap(0);
        r0 = sck_rises;
        push_op(8, 2);
        repeat (20) @(negedge clk);
        check(sck == 0 && sck_rises == r0, "R8", sck_rises - r0, 0);
        check(op_empty == 0, "R2", op_empty, 0);
        push_dat(8'hC3);
        repeat (40) @(negedge clk);
        check(cap_n == 1 && sck == 0, "R8", cap_n, 1);
        check(op_empty == 0, "R2", op_empty, 0);
        push_dat(8'h5A);
        wait_idle();
        check(cap_q[0] == 8'hC3 && cap_q[1] == 8'h5A, "R8", cap_q[1], 8'h5A);
        cap_en = 0;

        // R9: receive stalls on a full data FIFO
        for (int i = 0; i < 10; i++) rx_b[i] = $urandom_range(0, 255);
        rx_w = 2; gidx = 0; rx_act = 1;
        push_op(15, 10);
        repeat (200) @(negedge clk);
        check(dat_full == 1 && sck == 0, "R9", dat_full, 1);
        check(op_empty == 0, "R9", op_empty, 0);
        for (int i = 0; i < 10; i++) begin
            pop_dat(b);
            check(b == rx_b[i], "R9", b, rx_b[i]);
        end
        wait_idle();
        rx_act = 0;

        // R1: queue full, extra push dropped
        push_op(1, 1);
        push_op(8, 1);
        repeat (4) @(negedge clk);
        for (int i = 0; i < 4; i++) push_raw(1, 1);
        check(op_full == 1, "R1", op_full, 1);
        push_raw(0, 1);
        start_cap(0);
        push_dat(8'hA5);
        wait_idle();
        check(cs_n == 0, "R1", cs_n, 0);
        check(cap_n == 1 && cap_q[0] == 8'hA5, "R1", cap_q[0], 8'hA5);
        cap_en = 0;

        // R11: undefined codes are no-ops
        run_send(9, 1, 1, "R4");
        push_dat(8'h3C);
        r0 = sck_rises;
        push_op(5, 3); push_op(31, 511); push_op(13, 2);
        wait_idle();
        check(cs_n == 0 && io_oe == 4'b0011, "R11", io_oe, 3);
        check(sck_rises == r0, "R11", sck_rises - r0, 0);
        check(dat_empty == 0 && dat_rdata == 8'h3C, "R11", dat_rdata, 8'h3C);
        pop_dat(b);

        // R12: data FIFO flags and dropped push
        for (int i = 0; i < 8; i++) begin tx[i] = 8'h10 + i; push_dat(tx[i]); end
        check(dat_full == 1, "R12", dat_full, 1);
        push_dat_raw(8'hEE);
        for (int i = 0; i < 8; i++) begin
            pop_dat(b);
            check(b == tx[i], "R12", b, tx[i]);
        end
        @(negedge clk);
        check(dat_empty == 1, "R12", dat_empty, 1);

        // Random mix
        for (int k = 0; k < 24; k++) begin
            int kind, w, n, o, i;
            kind = $urandom_range(0, 2);
            w = $urandom_range(0, 2);
            n = $urandom_range(1, 6);
            if (kind == 0) run_send(8 + w, w, n, "R4");
            else if (kind == 1) run_recv(w, n);
            else begin
                o = w; i = $urandom_range(0, 2);
                run_send(16 + 3 * o + i, o, n, "R6");
                check(int'(io_oe) == (omask(o) & ~imask(i)), "R6", io_oe, omask(o) & ~imask(i));
            end
        end
        push_op(0, 1); wait_idle();
        check(cs_n == 1 && sck == 0, "R3", cs_n, 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule